// File: doc/BRIEF.md
# Region Cacheability Attribute Table

This block keeps one attribute word for each fixed 16 MB region of a 32-bit logical address space, which gives 256 entries in total. Each word carries two live flags. One says whether accesses to the region may be cached. The other says whether the region may be prefetched. Every other bit of the word is hardwired to zero.

A configuration port reads and writes entries by index. Reads are combinational from the index. Writes take effect at the clock edge. The lowest sixteen entries describe fixed internal regions: they always report a constant "cacheable, not prefetchable" value, and any write to them is dropped and flagged with a one-cycle error pulse.

A lookup port takes a full access address, selects the entry from its top eight bits, and returns that region's two flags in the same cycle. Software clears an entry to zero to keep a region out of the cache and out of the prefetcher, for example a window that several agents share for communication.

Top module: `rgn_attr_table`

## Requirements
- R1: After reset, every writable entry (index 16 to 255) reads as 32'h0000_0000.
- R2: Entries 0 to 15 always read as 32'h0000_0001, which means cacheable and not prefetchable.
- R3: A write to a writable entry stores bit 0 (cacheable) and bit 3 (prefetchable) of the write data. All other bits read back as zero, whatever value was written.
- R4: A write to an entry in 0 to 15 changes neither the readback nor the lookup result of that entry.
- R5: A write to an entry in 0 to 15 raises `cfg_wr_err` for exactly the one cycle after the write edge. A write to a writable entry, or no write at all, leaves `cfg_wr_err` low in the following cycle.
- R6: The lookup selects the entry from address bits [31:24]. `lk_cacheable` equals bit 0 and `lk_prefetchable` equals bit 3 of that entry, combinationally from `lk_addr`.
- R7: A write becomes visible to the lookup right after its clock edge. Before that edge the lookup shows the previous value.
- R8: Writing 0 to a writable entry makes its region neither cacheable nor prefetchable.
- R9: `cfg_rdata` follows `cfg_idx` combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration port |
| cfg_idx | input | 8 | Entry index for both read and write |
| cfg_wdata | input | 32 | Write data; only bits 0 and 3 are kept |
| cfg_rdata | output | 32 | Combinational readback of entry `cfg_idx` |
| cfg_wr_err | output | 1 | One-cycle pulse after a write to a read-only entry |
| lk_addr | input | 32 | Access address for the lookup |
| lk_cacheable | output | 1 | Cacheable flag of the region of `lk_addr` |
| lk_prefetchable | output | 1 | Prefetchable flag of the region of `lk_addr` |

## Verification
A corrupted entry in the table shows up in two places during the very cycle it is addressed: on `cfg_rdata` when the index selects it, and on the lookup flags when an address in that region is presented. The bench therefore checks the readback and the lookup of the same entry against each other.

A write mask that let a reserved bit through, or a decode that let a read-only entry be overwritten, becomes visible on the first read after the write edge. A misdecoded error pulse is wrong in the single cycle that follows the write.

// File: rtl/rgn_attr_pkg.sv
package rgn_attr_pkg;

    localparam int WORD_W    = 32;
    localparam int CACHE_POS = 0;
    localparam int PREF_POS  = 3;

    // Live content of one entry; the reserved bits are never stored
    typedef struct packed {
        logic pref;
        logic cache;
    } attr_t;

    localparam attr_t ATTR_NONE  = '{pref: 1'b0, cache: 1'b0};
    localparam attr_t ATTR_FIXED = '{pref: 1'b0, cache: 1'b1};

    // Place the flags at their bit positions; every other bit is zero
    function automatic logic [WORD_W-1:0] attr_to_word(attr_t a);
        logic [WORD_W-1:0] w;
        w            = '0;
        w[CACHE_POS] = a.cache;
        w[PREF_POS]  = a.pref;
        return w;
    endfunction

    // Keep only the two live bits of a full data word
    function automatic attr_t word_to_attr(logic [WORD_W-1:0] w);
        attr_t a;
        a.cache = w[CACHE_POS];
        a.pref  = w[PREF_POS];
        return a;
    endfunction

endpackage

// File: rtl/rgn_attr_wr_ctrl.sv
module rgn_attr_wr_ctrl
    import rgn_attr_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int RO_COUNT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [WORD_W-1:0]   wr_data,
    output logic                store_en,
    output attr_t               store_attr,
    output logic                wr_err
);
    localparam logic [IDX_W-1:0] RO_LIMIT = IDX_W'(RO_COUNT);

    logic hit_fixed;

    always_comb begin
        hit_fixed  = (wr_idx < RO_LIMIT);
        store_en   = wr_en && !hit_fixed;
        store_attr = word_to_attr(wr_data);
    end

    // The error pulse is registered, so it appears in the cycle after the write
    always_ff @(posedge clk) begin
        if (rst) wr_err <= 1'b0;
        else     wr_err <= wr_en && hit_fixed;
    end
endmodule

// File: rtl/rgn_attr_store.sv
module rgn_attr_store
    import rgn_attr_pkg::*;
#(
    parameter int    NUM_ENTRIES = 256,
    parameter int    RO_COUNT    = 16,
    parameter int    IDX_W       = 8,
    parameter attr_t FIXED_VAL   = ATTR_FIXED
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  attr_t            wr_attr,
    output attr_t            ent [NUM_ENTRIES]
);
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        if (i < RO_COUNT) begin : g_fixed
            assign ent[i] = FIXED_VAL;
        end else begin : g_flop
            attr_t q;
            always_ff @(posedge clk) begin
                if (rst)                                   q <= ATTR_NONE;
                else if (wr_en && wr_idx == IDX_W'(i))     q <= wr_attr;
            end
            assign ent[i] = q;
        end
    end
endmodule

// File: rtl/rgn_attr_rd_port.sv
module rgn_attr_rd_port
    import rgn_attr_pkg::*;
#(
    parameter int NUM_ENTRIES = 256,
    parameter int IDX_W       = 8
) (
    input  attr_t            ent [NUM_ENTRIES],
    input  logic [IDX_W-1:0] idx,
    output attr_t            sel
);
    always_comb sel = ent[idx];
endmodule

// File: rtl/rgn_attr_table.sv
module rgn_attr_table
    import rgn_attr_pkg::*;
#(
    parameter int  NUM_ENTRIES = 256,
    parameter int  ADDR_W      = 32,
    parameter int  RO_COUNT    = 16,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              cfg_wr_err,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_cacheable,
    output logic              lk_prefetchable
);
    attr_t            ent [NUM_ENTRIES];
    logic             store_en;
    attr_t            store_attr;
    attr_t            cfg_sel;
    attr_t            lk_sel;
    logic [IDX_W-1:0] lk_idx;
    logic             unused_addr_lo;

    // The region index is the top IDX_W bits of the address
    assign lk_idx         = lk_addr[ADDR_W-1 -: IDX_W];
    assign unused_addr_lo = ^lk_addr[ADDR_W-IDX_W-1:0];

    rgn_attr_wr_ctrl #(.IDX_W(IDX_W), .RO_COUNT(RO_COUNT)) u_wr (
        .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_idx(cfg_idx),
        .wr_data(cfg_wdata), .store_en(store_en), .store_attr(store_attr),
        .wr_err(cfg_wr_err)
    );

    rgn_attr_store #(.NUM_ENTRIES(NUM_ENTRIES), .RO_COUNT(RO_COUNT),
                     .IDX_W(IDX_W), .FIXED_VAL(ATTR_FIXED)) u_store (
        .clk(clk), .rst(rst), .wr_en(store_en), .wr_idx(cfg_idx),
        .wr_attr(store_attr), .ent(ent)
    );

    rgn_attr_rd_port #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_cfg_rd (
        .ent(ent), .idx(cfg_idx), .sel(cfg_sel)
    );

    rgn_attr_rd_port #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_lk_rd (
        .ent(ent), .idx(lk_idx), .sel(lk_sel)
    );

    assign cfg_rdata       = attr_to_word(cfg_sel);
    assign lk_cacheable    = lk_sel.cache;
    assign lk_prefetchable = lk_sel.pref;
endmodule

// File: rtl/rgn_attr_checker.sv
module rgn_attr_checker #(
    parameter int IDX_W    = 8,
    parameter int ADDR_W   = 32,
    parameter int RO_COUNT = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr_en,
    input logic [IDX_W-1:0]  cfg_idx,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       cfg_rdata,
    input logic              cfg_wr_err,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_cacheable,
    input logic              lk_prefetchable
);
    localparam logic [IDX_W-1:0] RO_LIMIT = IDX_W'(RO_COUNT);

    assert_fixed_read_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_idx < RO_LIMIT) |-> (cfg_rdata == 32'h0000_0001));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & ~32'h0000_0009) == 32'h0);

    assert_err_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_idx < RO_LIMIT) |=> cfg_wr_err);

    assert_no_err_R5: assert property (@(posedge clk) disable iff (rst)
        !(cfg_wr_en && cfg_idx < RO_LIMIT) |=> !cfg_wr_err);

    assert_lookup_match_R6: assert property (@(posedge clk) disable iff (rst)
        (lk_addr[ADDR_W-1 -: IDX_W] == cfg_idx) |->
        (lk_cacheable == cfg_rdata[0] && lk_prefetchable == cfg_rdata[3]));

    assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_idx >= RO_LIMIT) |=>
        (!$stable(cfg_idx) || cfg_rdata == ($past(cfg_wdata) & 32'h0000_0009)));
endmodule

bind rgn_attr_table rgn_attr_checker #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .RO_COUNT(RO_COUNT)) u_chk (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_wr_err(cfg_wr_err),
    .lk_addr(lk_addr), .lk_cacheable(lk_cacheable), .lk_prefetchable(lk_prefetchable)
);

// File: tb/rgn_attr_table_bench.sv
`timescale 1ns/1ps
module rgn_attr_table_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_idx = 8'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        cfg_wr_err;
    logic [31:0] lk_addr = 32'd0;
    logic        lk_cacheable;
    logic        lk_prefetchable;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rgn_attr_table u_rgn_attr_table (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_wr_err(cfg_wr_err),
        .lk_addr(lk_addr), .lk_cacheable(lk_cacheable), .lk_prefetchable(lk_prefetchable)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive a write on the falling edge; return 1 ns after the write edge
    task automatic do_write(input logic [7:0] idx, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [7:0] idx, input logic [31:0] exp);
        cfg_idx = idx; #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic lk_chk(input string req, input logic [31:0] addr, input logic c, input logic p);
        lk_addr = addr; #1;
        check(req, {30'd0, lk_prefetchable, lk_cacheable}, {30'd0, p, c});
    endtask

    task automatic t_reset;
        // R1: writable entries cleared
        read_chk("R1 entry16", 8'd16, 32'h0);
        read_chk("R1 entry255", 8'd255, 32'h0);
        read_chk("R1 entry128", 8'd128, 32'h0);
        check("R5 err low after reset", {31'd0, cfg_wr_err}, 32'd0);
    endtask

    task automatic t_fixed;
        // R2: constant value in entries 0..15
        read_chk("R2 entry0", 8'd0, 32'h1);
        read_chk("R2 entry15", 8'd15, 32'h1);
        lk_chk("R2 lookup 0x0C region", 32'h0C12_3456, 1'b1, 1'b0);
    endtask

    task automatic t_mask;
        // R3: only bits 0 and 3 survive
        do_write(8'd40, 32'hFFFF_FFFF);
        check("R5 no err on writable", {31'd0, cfg_wr_err}, 32'd0);
        read_chk("R3 all ones", 8'd40, 32'h9);
        do_write(8'd41, 32'hFFFF_FFF6);
        read_chk("R3 reserved only", 8'd41, 32'h0);
        do_write(8'd42, 32'h0000_0008);
        read_chk("R3 prefetch only", 8'd42, 32'h8);
        do_write(8'd16, 32'h0000_0001);
        read_chk("R3 lowest writable", 8'd16, 32'h1);
    endtask

    task automatic t_ro_write;
        // R4 and R5: dropped write, one-cycle error pulse
        do_write(8'd5, 32'h0000_0008);
        check("R5 err pulse", {31'd0, cfg_wr_err}, 32'd1);
        read_chk("R4 entry5 unchanged", 8'd5, 32'h1);
        lk_chk("R4 lookup unchanged", 32'h05AB_CDEF, 1'b1, 1'b0);
        @(posedge clk); #1;
        check("R5 err one cycle", {31'd0, cfg_wr_err}, 32'd0);
        do_write(8'd15, 32'h0);
        check("R5 err entry15", {31'd0, cfg_wr_err}, 32'd1);
        read_chk("R4 entry15 unchanged", 8'd15, 32'h1);
    endtask

    task automatic t_lookup;
        // R6: index from bits [31:24]
        do_write(8'hA7, 32'h0000_0008);
        do_write(8'hA8, 32'h0000_0001);
        lk_chk("R6 region A7 low", 32'hA700_0000, 1'b0, 1'b1);
        lk_chk("R6 region A7 high", 32'hA7FF_FFFF, 1'b0, 1'b1);
        lk_chk("R6 region A8", 32'hA800_0000, 1'b1, 1'b0);
        lk_chk("R6 region A6 untouched", 32'hA6FF_FFFF, 1'b0, 1'b0);
    endtask

    task automatic t_visible;
        // R7: not visible before the edge, visible right after
        lk_addr = 32'h6012_0000;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_idx = 8'h60; cfg_wdata = 32'h9;
        #5;
        check("R7 before edge", {31'd0, lk_cacheable}, 32'd0);
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
        check("R7 after edge", {30'd0, lk_prefetchable, lk_cacheable}, 32'd3);
    endtask

    task automatic t_clear;
        // R8: writing zero clears both flags
        do_write(8'h60, 32'h0);
        read_chk("R8 readback", 8'h60, 32'h0);
        lk_chk("R8 lookup", 32'h6000_0100, 1'b0, 1'b0);
    endtask

    task automatic t_comb_read;
        // R9: readback changes with the index, no clock edge
        @(negedge clk);
        cfg_idx = 8'd40; #2;
        check("R9 idx 40", cfg_rdata, 32'h9);
        cfg_idx = 8'd3; #2;
        check("R9 idx 3", cfg_rdata, 32'h1);
        cfg_idx = 8'd42; #2;
        check("R9 idx 42", cfg_rdata, 32'h8);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_fixed();
        t_mask();
        t_ro_write();
        t_lookup();
        t_visible();
        t_clear();
        t_comb_read();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule